// File: doc/BRIEF.md
# Halving Tree Sum Reducer

This block keeps one partial sum for each of P notional processors in an internal register array and folds them into a single total. Software or an upstream engine first writes the partial sums through a simple indexed write port while the block is idle. A one-cycle start pulse then launches the reduction. Each step pairs every slot in the lower half of the live range with its partner in the upper half and adds them in parallel. When the live range has an odd length, the leftover top slot is folded into slot 0 in the same step.

A step is a barrier: all adds of one step commit on one clock edge before the next step reads the array. When only one live slot remains, the block presents the total on its result port and raises a one-cycle done pulse. The result then holds until the next completed run. The live count may start at any value, including values that are not powers of two, such as the default of 100.

Top module: `tree_sum_reducer`

## Requirements
- R1: After synchronous reset, `done` is 0 and `total` is 0.
- R2: While the block is idle, a write with `ld_valid` high stores `ld_value` into slot `ld_index`. A write whose index is P or larger changes no slot.
- R3: A start pulse while idle reduces slots 0..P-1 to their sum. Each step halves the live count n to floor(n/2), and slot i, for i below the new count, adds slot i+floor(n/2).
- R4: When the live count n is odd, slot 0 additionally adds slot n-1 in the same step, so no element is lost for any P.
- R5: With S halving steps needed to reach a count of 1, `done` first reads high S+1 clock edges after the edge that samples `start`. For P=100, S=6.
- R6: `done` stays high for exactly one cycle per run.
- R7: `total` changes only on the edge that raises `done`. It holds through later idle writes until the next run completes.
- R8: Writes and start pulses that arrive during a run are ignored. The run's timing and total are unchanged.
- R9: For P=1 there are no steps: `done` rises one edge after start, and `total` equals slot 0.
- R10: Additions are 32-bit with wraparound modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Write strobe for one partial sum |
| ld_index | input | IDX_W (max(1,clog2 P)) | Slot to write |
| ld_value | input | DATA_W (32) | Partial sum value |
| start | input | 1 | Begin a reduction (honoured only when idle) |
| done | output | 1 | One-cycle pulse when the total is ready |
| total | output | DATA_W (32) | Final sum, held until the next run completes |

## Verification
The result of a run is due S+1 edges after the start edge, where S is the number of halvings from P down to 1. The bench computes S from P on its own, counts falling edges after the start edge, and requires the first high `done` exactly at count S+1. It checks `total` in that same half-cycle and confirms that `done` is low one cycle later. Idle writes after completion and mid-run writes and starts are followed by a sample of `total` or a full run before the next stimulus, so that their absence of effect is seen at the ports.

// File: rtl/tree_sum_pkg.sv
package tree_sum_pkg;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Width of a slot index; never zero so a single-slot build still has a port.
    function automatic int idx_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Width able to hold the live count from P down to 1.
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/tree_sum_sched.sv
module tree_sum_sched
    import tree_sum_pkg::*;
#(
    parameter int NUM_SLOTS = 100,
    parameter int CNT_W     = cnt_bits(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             step_en,
    output logic             finish,
    output logic [CNT_W-1:0] live_cnt
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_SLOTS);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            live_cnt <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q  <= PH_RUN;
                        live_cnt <= FULL_CNT;
                    end
                end
                PH_RUN: begin
                    if (live_cnt > ONE_CNT) begin
                        live_cnt <= live_cnt >> 1;
                    end else begin
                        phase_q <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        busy    = (phase_q == PH_RUN);
        step_en = busy && (live_cnt > ONE_CNT);
        finish  = busy && (live_cnt == ONE_CNT);
    end

    AST_CNT_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        step_en |=> (live_cnt < $past(live_cnt)))
        else $error("live count did not shrink"); // R3

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (live_cnt <= FULL_CNT) && (live_cnt != '0))
        else $error("live count out of range"); // R3

    AST_FINISH_IDLES: assert property (@(posedge clk) disable iff (rst)
        finish |=> !busy)
        else $error("run did not end after final step"); // R5

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start && step_en) |=> busy && (live_cnt != FULL_CNT || FULL_CNT == ONE_CNT))
        else $error("start restarted a run"); // R8

endmodule

// File: rtl/tree_sum_slots.sv
module tree_sum_slots
    import tree_sum_pkg::*;
#(
    parameter int NUM_SLOTS = 100,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = idx_bits(NUM_SLOTS),
    parameter int CNT_W     = cnt_bits(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              step_en,
    input  logic [CNT_W-1:0]  live_cnt,
    output logic [DATA_W-1:0] head
);

    logic [DATA_W-1:0] slots [NUM_SLOTS];
    logic [DATA_W-1:0] nxt   [NUM_SLOTS];
    logic [DATA_W-1:0] tail_val;
    int                half_n;
    int                tail_i;

    // One barrier step: every pair add plus the odd fold-in settle together.
    always_comb begin
        half_n = int'(live_cnt) / 2;
        tail_i = int'(live_cnt) - 1;
        tail_val = '0;
        if (live_cnt[0] && tail_i > 0 && tail_i < NUM_SLOTS) begin
            tail_val = slots[tail_i];
        end
        for (int i = 0; i < NUM_SLOTS; i++) begin
            nxt[i] = slots[i];
            if (i < half_n && (i + half_n) < NUM_SLOTS) begin
                nxt[i] = slots[i] + slots[i + half_n];
            end
        end
        nxt[0] = nxt[0] + tail_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                slots[i] <= '0;
            end
        end else if (step_en) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                slots[i] <= nxt[i];
            end
        end else if (wr_en) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (int'(wr_idx) == i) begin
                    slots[i] <= wr_data;
                end
            end
        end
    end

    assign head = slots[0];

    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !(wr_en && wr_idx == '0)) |=> $stable(head))
        else $error("slot 0 changed without a step or write"); // R2

    AST_NO_WRITE_IN_STEP: assert property (@(posedge clk) disable iff (rst)
        !(step_en && wr_en))
        else $error("write admitted during a step"); // R8

endmodule

// File: rtl/tree_sum_reducer.sv
module tree_sum_reducer
    import tree_sum_pkg::*;
#(
    parameter int NUM_SLOTS = 100,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = idx_bits(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [IDX_W-1:0]  ld_index,
    input  logic [DATA_W-1:0] ld_value,
    input  logic              start,
    output logic              done,
    output logic [DATA_W-1:0] total
);

    localparam int CNT_W = cnt_bits(NUM_SLOTS);

    logic             busy;
    logic             step_en;
    logic             finish;
    logic [CNT_W-1:0] live_cnt;
    logic [DATA_W-1:0] head;
    logic             wr_en;

    assign wr_en = ld_valid && !busy;

    tree_sum_sched #(
        .NUM_SLOTS (NUM_SLOTS),
        .CNT_W     (CNT_W)
    ) u_sched (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .busy     (busy),
        .step_en  (step_en),
        .finish   (finish),
        .live_cnt (live_cnt)
    );

    tree_sum_slots #(
        .NUM_SLOTS (NUM_SLOTS),
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W)
    ) u_slots (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (ld_index),
        .wr_data  (ld_value),
        .step_en  (step_en),
        .live_cnt (live_cnt),
        .head     (head)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            total <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                total <= head;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("done held beyond one cycle"); // R6

    AST_TOTAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(total))
        else $error("total moved outside completion"); // R7

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && $past(busy))
        else $error("done without a finished run"); // R5

endmodule

// File: tb/tree_sum_reducer_tb.sv
`timescale 1ns/1ps
module tree_sum_reducer_tb;
    import tree_sum_pkg::*;

    localparam int NDUT = 4;
    localparam int IW0 = idx_bits(100);
    localparam int IW1 = idx_bits(1);
    localparam int IW2 = idx_bits(7);
    localparam int IW3 = idx_bits(16);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [NDUT-1:0] ld_valid = '0;
    logic [NDUT-1:0] start = '0;
    logic [7:0]  ld_idx = '0;
    logic [31:0] ld_value = '0;
    logic [NDUT-1:0] done;
    logic [31:0] total [NDUT];

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tree_sum_reducer #(.NUM_SLOTS(100)) u_dut (
        .clk(clk), .rst(rst), .ld_valid(ld_valid[0]), .ld_index(ld_idx[IW0-1:0]),
        .ld_value(ld_value), .start(start[0]), .done(done[0]), .total(total[0]));
    tree_sum_reducer #(.NUM_SLOTS(1)) u_dut_p1 (
        .clk(clk), .rst(rst), .ld_valid(ld_valid[1]), .ld_index(ld_idx[IW1-1:0]),
        .ld_value(ld_value), .start(start[1]), .done(done[1]), .total(total[1]));
    tree_sum_reducer #(.NUM_SLOTS(7)) u_dut_p7 (
        .clk(clk), .rst(rst), .ld_valid(ld_valid[2]), .ld_index(ld_idx[IW2-1:0]),
        .ld_value(ld_value), .start(start[2]), .done(done[2]), .total(total[2]));
    tree_sum_reducer #(.NUM_SLOTS(16)) u_dut_p16 (
        .clk(clk), .rst(rst), .ld_valid(ld_valid[3]), .ld_index(ld_idx[IW3-1:0]),
        .ld_value(ld_value), .start(start[3]), .done(done[3]), .total(total[3]));

    function automatic int slots_of(input int sel);
        case (sel)
            0: return 100;
            1: return 1;
            2: return 7;
            default: return 16;
        endcase
    endfunction

    function automatic int halvings(input int n);
        int c = n;
        int s = 0;
        while (c > 1) begin
            c = c / 2;
            s++;
        end
        return s;
    endfunction

    function automatic logic [31:0] pattern(input int mode, input int i);
        case (mode)
            0: return 32'(i * 3 + 1);
            1: return 32'hFFFF_FFF0 + 32'(i);
            2: return 32'h1 << (i % 32);
            default: return 32'(i * i) ^ 32'h0000_A5A5;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_slot(input int sel, input int idx, input logic [31:0] v);
        @(negedge clk);
        ld_valid[sel] = 1'b1;
        ld_idx = 8'(idx);
        ld_value = v;
        @(negedge clk);
        ld_valid[sel] = 1'b0;
    endtask

    task automatic fill(input int sel, input int mode, output logic [31:0] sum);
        sum = '0;
        for (int i = 0; i < slots_of(sel); i++) begin
            write_slot(sel, i, pattern(mode, i));
            sum = sum + pattern(mode, i);
        end
    endtask

    // Start a run; optionally disturb it mid-run; check latency, total and pulse width.
    task automatic run_check(input int sel, input logic [31:0] exp, input bit disturb, input string req);
        int n = 0;
        int lat = halvings(slots_of(sel)) + 1;
        @(negedge clk);
        start[sel] = 1'b1;
        @(negedge clk);
        start[sel] = 1'b0;
        n = 0;
        while (n < 300) begin
            if (disturb && n == 1) begin
                ld_valid[sel] = 1'b1; ld_idx = 8'd0; ld_value = 32'hDEAD_0000;
                start[sel] = 1'b1;
            end
            @(negedge clk);
            ld_valid[sel] = 1'b0;
            start[sel] = 1'b0;
            n++;
            if (done[sel]) break;
        end
        chk(n == lat, {req, " R5 latency"}, 32'(n), 32'(lat));
        chk(total[sel] == exp, {req, " R3 total"}, total[sel], exp);
        @(negedge clk);
        chk(done[sel] == 1'b0, "R6 done one cycle", 32'(done[sel]), 32'd0);
    endtask

    task automatic t_reset();
        for (int d = 0; d < NDUT; d++) begin
            chk(done[d] == 1'b0, "R1 done at reset", 32'(done[d]), 32'd0);
            chk(total[d] == 32'd0, "R1 total at reset", total[d], 32'd0);
        end
    endtask

    task automatic t_p100_ramp();
        logic [31:0] s;
        fill(0, 0, s);
        run_check(0, s, 1'b0, "R4 P=100 odd steps");
    endtask

    task automatic t_p100_wrap();
        logic [31:0] s;
        fill(0, 1, s);
        run_check(0, s, 1'b0, "R10 P=100 wrap");
    endtask

    task automatic t_p100_disturb();
        logic [31:0] s;
        fill(0, 3, s);
        run_check(0, s, 1'b1, "R8 mid-run write/start");
    endtask

    task automatic t_hold_after_done();
        logic [31:0] keep = total[0];
        write_slot(0, 0, 32'h1234_5678);
        repeat (3) @(negedge clk);
        chk(total[0] == keep, "R7 total held after idle write", total[0], keep);
        chk(done[0] == 1'b0, "R7 no done from write", 32'(done[0]), 32'd0);
    endtask

    task automatic t_p1();
        write_slot(1, 0, 32'hCAFE_F00D);
        run_check(1, 32'hCAFE_F00D, 1'b0, "R9 P=1");
    endtask

    task automatic t_p7();
        logic [31:0] s;
        fill(2, 3, s);
        write_slot(2, 7, 32'h0BAD_0BAD);
        run_check(2, s, 1'b0, "R2 R4 P=7 out-of-range index");
        fill(2, 2, s);
        run_check(2, s, 1'b0, "R4 P=7 bits");
    endtask

    task automatic t_p16();
        logic [31:0] s;
        fill(3, 0, s);
        run_check(3, s, 1'b0, "R3 P=16");
        fill(3, 1, s);
        run_check(3, s, 1'b0, "R10 P=16 wrap");
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_p100_ramp();
        t_p100_wrap();
        t_p100_disturb();
        t_hold_after_done();
        t_p1();
        t_p7();
        t_p16();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

endmodule